// File: doc/BRIEF.md
# Power-Mode Sequencer with Clock Gating

This block decides which clocks and supplies of a small microcontroller are running. Software writes two registers. The mode register selects a CPU-only stop (idle) or a full shutdown (power-down). It also holds the clock-speed choice, the wake-source choice and whether a boot phase runs on wake-up. The gate register holds one closing bit per peripheral clock. From these registers and from the interrupt, watchdog and wake inputs, the block drives the CPU clock enable, the peripheral clock enables, the main regulator and fast oscillator enables, the port tri-state control and a CPU reset request.

Idle stops only the CPU clock. The oscillator, the regulator and any open peripheral clocks keep running. An enabled interrupt resumes the CPU without a reset.

Power-down turns off the regulator and the fast oscillator and tri-states the ports. One selected wake event starts the return sequence. The first wake phase waits a set number of slow reference ticks and also waits for the supplies to report ready. A second phase then holds the CPU in reset while a boot routine runs, but only when the wake-select bit asks for it. Both phase lengths are parameters counted in reference ticks.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the CPU clock, regulator and fast oscillator are enabled, all peripheral clocks are off, the ports are not tri-stated, the reset request is low and the speed output is 0.
- R2: A write with `wr_sel`=1 loads the gate register. Gate i is open (clock enabled) exactly when bit i is 0, so writing all zeros enables every peripheral clock.
- R3: A mode write (`wr_sel`=0) with bit 0 set and bit 1 clear enters idle. The CPU clock enable is still high after the write edge and goes low after the next edge. Regulator, oscillator and open peripheral clocks are unaffected.
- R4: In idle, a sampled `irq_pend` brings the CPU clock back after two edges, with no reset request. The idle bit is cleared, so the block stays active afterwards.
- R5: An idle write made while `irq_pend` is high is ignored, and the CPU clock stays on.
- R6: Mode bit 3 (speed setting, output `cpu_fast`) is kept unchanged through idle and through power-down with wake-up.
- R7: `wdt_ovf` sampled in active or idle raises `cpu_rst_req` for exactly one cycle. It also returns the block to active, clears the mode register and closes all peripheral gates.
- R8: `rst_n` low in any state, power-down included, gives the R1 state at once.
- R9: A mode write with bit 1 set enters power-down after the write edge. CPU clock, regulator, oscillator and all peripheral clocks go off and the ports are tri-stated. `ext0_keep` is high when mode bit 4 is 0.
- R10: Mode bit 4 selects the single honoured wake source: 0 selects `ext_wake` and 1 selects `rtc_wake`. The other source has no effect.
- R11: On wake, the regulator and oscillator turn on at once. The CPU clock stays off until `WAKE_RDY_TICKS` reference ticks have been counted and `supply_rdy` is high; the change takes effect on the following edge.
- R12: With mode bit 2 set, a boot phase of `WAKE_BOOT_TICKS` ticks follows, with the CPU clock on and `cpu_rst_req` high. With bit 2 clear there is no boot phase and no reset request.
- R13: On return to active, the ports leave tri-state and the peripheral clocks follow the gate register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | 0 mode register, 1 gate register |
| wr_data | input | DW | write data |
| irq_pend | input | 1 | an enabled interrupt is pending |
| wdt_ovf | input | 1 | watchdog overflow |
| ext_wake | input | 1 | external interrupt 0 wake event |
| rtc_wake | input | 1 | real-time-clock wake pulse |
| ref_tick | input | 1 | slow reference clock tick, one cycle wide |
| supply_rdy | input | 1 | regulator, oscillator and flash ready |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_fast | output | 1 | speed setting, 1 = fast mode |
| periph_clk_en | output | NPERIPH | per-peripheral clock enables |
| main_reg_en | output | 1 | main regulator enable |
| fast_osc_en | output | 1 | fast oscillator enable |
| port_tristate | output | 1 | tri-state the port pins |
| ext0_keep | output | 1 | keep the external interrupt 0 pin enabled while ports are tri-stated |
| cpu_rst_req | output | 1 | CPU reset request |

## Verification
The hardest situation to reach is a wake sequence whose tick count has already run out while the supplies are still not ready. From outside, this looks the same as a counter that is too slow. The stimulus therefore holds `supply_rdy` low, issues every reference tick by hand, waits extra cycles with the CPU clock still off, and then raises `supply_rdy` and expects the change on the next edge. Ticks are issued one at a time, so the edge where the CPU clock or reset request changes is known exactly. This is used in both the booted and the non-booted wake.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int NPERIPH         = 8,
  parameter int DW              = 8,
  parameter int WAKE_RDY_TICKS  = 6,
  parameter int WAKE_BOOT_TICKS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic               irq_pend,
  input  logic               wdt_ovf,
  input  logic               ext_wake,
  input  logic               rtc_wake,
  input  logic               ref_tick,
  input  logic               supply_rdy,
  output logic               cpu_clk_en,
  output logic               cpu_fast,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               main_reg_en,
  output logic               fast_osc_en,
  output logic               port_tristate,
  output logic               ext0_keep,
  output logic               cpu_rst_req
);
  localparam int CNT_MAX = (WAKE_RDY_TICKS > WAKE_BOOT_TICKS) ? WAKE_RDY_TICKS : WAKE_BOOT_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RDY_END  = CNT_W'(WAKE_RDY_TICKS);
  localparam logic [CNT_W-1:0] BOOT_END = CNT_W'(WAKE_BOOT_TICKS);

  typedef enum logic [2:0] {
    S_ACT, S_IDLE_IN, S_IDLE, S_IDLE_OUT, S_PD, S_WK_RDY, S_WK_BOOT
  } state_t;

  state_t             state;
  logic [4:0]         mode_q;
  logic [NPERIPH-1:0] gate_q;
  logic [CNT_W-1:0]   cnt;
  logic               wdt_rst_q;

  wire running  = (state == S_ACT) || (state == S_IDLE_IN) || (state == S_IDLE) || (state == S_IDLE_OUT);
  wire wake_hit = mode_q[4] ? rtc_wake : ext_wake;
  wire [4:0] mode_wr = {wr_data[4:1], wr_data[0] & ~irq_pend};

  assign cpu_clk_en    = (state == S_ACT) || (state == S_IDLE_IN) || (state == S_WK_BOOT);
  assign cpu_fast      = mode_q[3];
  assign periph_clk_en = running ? ~gate_q : '0;
  assign main_reg_en   = (state != S_PD);
  assign fast_osc_en   = (state != S_PD);
  assign port_tristate = !running;
  assign ext0_keep     = !running && !mode_q[4];
  assign cpu_rst_req   = (state == S_WK_BOOT) || wdt_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_ACT;
      mode_q    <= '0;
      gate_q    <= '1;
      cnt       <= '0;
      wdt_rst_q <= 1'b0;
    end else begin
      wdt_rst_q <= wdt_ovf && running;
      if (wdt_ovf && running) begin
        state  <= S_ACT;
        mode_q <= '0;
        gate_q <= '1;
      end else begin
        case (state)
          S_ACT: if (wr_en) begin
            if (wr_sel) gate_q <= wr_data[NPERIPH-1:0];
            else begin
              mode_q <= mode_wr;
              if (mode_wr[1])      state <= S_PD;
              else if (mode_wr[0]) state <= S_IDLE_IN;
            end
          end
          S_IDLE_IN:  state <= S_IDLE;
          S_IDLE:     if (irq_pend) state <= S_IDLE_OUT;
          S_IDLE_OUT: begin
            state     <= S_ACT;
            mode_q[0] <= 1'b0;
          end
          S_PD: if (wake_hit) begin
            state <= S_WK_RDY;
            cnt   <= '0;
          end
          S_WK_RDY: begin
            if (cnt == RDY_END && supply_rdy) begin
              cnt <= '0;
              if (mode_q[2]) state <= S_WK_BOOT;
              else begin
                state     <= S_ACT;
                mode_q[1] <= 1'b0;
              end
            end else if (ref_tick && cnt != RDY_END) cnt <= cnt + 1'b1;
          end
          S_WK_BOOT: begin
            if (cnt == BOOT_END) begin
              state     <= S_ACT;
              mode_q[1] <= 1'b0;
            end else if (ref_tick) cnt <= cnt + 1'b1;
          end
          default: state <= S_ACT;
        endcase
      end
    end
  end

  assert_idle_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT && wr_en && !wr_sel && wr_data[0] && !wr_data[1] && irq_pend && !wdt_ovf) |=> cpu_clk_en);

  assert_idle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && irq_pend && !wdt_ovf) |=> (!cpu_clk_en && !cpu_rst_req) ##1 cpu_clk_en);

  assert_wdt_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && running) |=> (cpu_rst_req && cpu_clk_en && periph_clk_en == '0));

  assert_pd_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_reg_en) |-> (!cpu_clk_en && port_tristate && periph_clk_en == '0));

  assert_wait_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WK_RDY && !supply_rdy) |=> !cpu_clk_en);

  assert_no_boot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WK_RDY && !mode_q[2]) |=> !cpu_rst_req);

  assert_speed_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(wr_en)) |=> $stable(cpu_fast));
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int NP = 8, RDY = 6, BOOT = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic irq_pend = 0, wdt_ovf = 0, ext_wake = 0, rtc_wake = 0, ref_tick = 0, supply_rdy = 1;
  logic cpu_clk_en, cpu_fast, main_reg_en, fast_osc_en, port_tristate, ext0_keep, cpu_rst_req;
  logic [NP-1:0] periph_clk_en;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.NPERIPH(NP), .DW(8), .WAKE_RDY_TICKS(RDY), .WAKE_BOOT_TICKS(BOOT)) i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_pend(irq_pend), .wdt_ovf(wdt_ovf), .ext_wake(ext_wake), .rtc_wake(rtc_wake),
    .ref_tick(ref_tick), .supply_rdy(supply_rdy), .cpu_clk_en(cpu_clk_en), .cpu_fast(cpu_fast),
    .periph_clk_en(periph_clk_en), .main_reg_en(main_reg_en), .fast_osc_en(fast_osc_en),
    .port_tristate(port_tristate), .ext0_keep(ext0_keep), .cpu_rst_req(cpu_rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); ref_tick = 1;
    @(negedge clk); ref_tick = 0;
  endtask

  task automatic t_reset();
    chk("R1 cpu clk", cpu_clk_en, 1);
    chk("R1 periph", periph_clk_en, 0);
    chk("R1 supplies", {main_reg_en, fast_osc_en}, 2'b11);
    chk("R1 ports/rst/fast", {port_tristate, cpu_rst_req, cpu_fast}, 0);
  endtask

  task automatic t_periph();
    wr(1, 8'hA5); chk("R2 pattern", periph_clk_en, 8'h5A);
    wr(1, 8'h00); chk("R2 all on", periph_clk_en, 8'hFF);
    wr(1, 8'hFF); chk("R2 all off", periph_clk_en, 8'h00);
  endtask

  task automatic t_idle();
    wr(1, 8'h0F);
    wr(0, 8'h09);
    chk("R3 clk after write edge", cpu_clk_en, 1);
    @(negedge clk);
    chk("R3 clk stopped", cpu_clk_en, 0);
    chk("R3 supplies on", {main_reg_en, fast_osc_en}, 2'b11);
    chk("R3 periph kept", periph_clk_en, 8'hF0);
    repeat (3) @(negedge clk);
    chk("R3 stays idle", cpu_clk_en, 0);
    irq_pend = 1;
    @(negedge clk); irq_pend = 0;
    chk("R4 exit first edge", cpu_clk_en, 0);
    @(negedge clk);
    chk("R4 clk back", cpu_clk_en, 1);
    chk("R4 no reset", cpu_rst_req, 0);
    chk("R6 speed after idle", cpu_fast, 1);
    repeat (3) @(negedge clk);
    chk("R4 idle bit cleared", cpu_clk_en, 1);
  endtask

  task automatic t_idle_blocked();
    irq_pend = 1;
    wr(0, 8'h01);
    @(negedge clk);
    chk("R5 write ignored", cpu_clk_en, 1);
    irq_pend = 0;
    repeat (2) @(negedge clk);
    chk("R5 still active", cpu_clk_en, 1);
  endtask

  task automatic t_wdt();
    wr(1, 8'h00);
    wr(0, 8'h09);
    @(negedge clk);
    chk("R7 in idle", cpu_clk_en, 0);
    wdt_ovf = 1;
    @(negedge clk); wdt_ovf = 0;
    chk("R7 reset req", cpu_rst_req, 1);
    chk("R7 clk on", cpu_clk_en, 1);
    chk("R7 gates closed", periph_clk_en, 0);
    chk("R7 mode cleared", cpu_fast, 0);
    @(negedge clk);
    chk("R7 one cycle", cpu_rst_req, 0);
  endtask

  task automatic t_pd_ext();
    wr(1, 8'h00);
    wr(0, 8'h0A);
    chk("R9 supplies off", {main_reg_en, fast_osc_en}, 0);
    chk("R9 cpu/periph off", {cpu_clk_en, periph_clk_en}, 0);
    chk("R9 tristate+ext0", {port_tristate, ext0_keep}, 2'b11);
    @(negedge clk); rtc_wake = 1;
    @(negedge clk); rtc_wake = 0;
    chk("R10 rtc ignored", main_reg_en, 0);
    @(negedge clk); ext_wake = 1;
    @(negedge clk); ext_wake = 0;
    chk("R11 supplies on at wake", {main_reg_en, fast_osc_en}, 2'b11);
    chk("R11 cpu held", cpu_clk_en, 0);
    for (int k = 0; k < RDY - 1; k++) tick();
    chk("R11 not early", cpu_clk_en, 0);
    tick();
    chk("R11 count done, one edge left", cpu_clk_en, 0);
    chk("R12 no reset in wake", cpu_rst_req, 0);
    @(negedge clk);
    chk("R11 cpu runs", cpu_clk_en, 1);
    chk("R12 no boot reset", cpu_rst_req, 0);
    chk("R13 periph restored", periph_clk_en, 8'hFF);
    chk("R13 ports enabled", port_tristate, 0);
    chk("R6 speed after pd", cpu_fast, 1);
  endtask

  task automatic t_pd_rtc_boot();
    wr(0, 8'h16);
    chk("R9 ext0 released", {port_tristate, ext0_keep}, 2'b10);
    @(negedge clk); ext_wake = 1;
    @(negedge clk); ext_wake = 0;
    chk("R10 ext ignored", main_reg_en, 0);
    supply_rdy = 0;
    @(negedge clk); rtc_wake = 1;
    @(negedge clk); rtc_wake = 0;
    chk("R10 rtc wakes", main_reg_en, 1);
    for (int k = 0; k < RDY; k++) tick();
    repeat (4) @(negedge clk);
    chk("R11 waits for supply", {cpu_clk_en, cpu_rst_req}, 0);
    supply_rdy = 1;
    @(negedge clk);
    chk("R12 boot phase", {cpu_clk_en, cpu_rst_req}, 2'b11);
    for (int k = 0; k < BOOT; k++) tick();
    chk("R12 boot last edge", cpu_rst_req, 1);
    @(negedge clk);
    chk("R12 boot ends", {cpu_clk_en, cpu_rst_req}, 2'b10);
    chk("R13 ports enabled", port_tristate, 0);
  endtask

  task automatic t_rst_pd();
    wr(0, 8'h0A);
    chk("R8 in pd", main_reg_en, 0);
    #1 rst_n = 0;
    #1 chk("R8 async reset", {main_reg_en, cpu_clk_en}, 2'b11);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R8 reset state", {cpu_clk_en, port_tristate, cpu_fast, cpu_rst_req}, 4'b1000);
    chk("R8 gates closed", periph_clk_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_periph();
    t_idle();
    t_idle_blocked();
    t_wdt();
    t_pd_ext();
    t_pd_rtc_boot();
    t_rst_pd();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule